// File: doc/BRIEF.md
# SMBus Packet Error Check Unit

This block sits beside the byte-level protocol engine of an SMBus/PMBus target and owns the packet error code. The engine hands it every byte that crosses the bus, whichever side sent it. It also raises one strobe when a message begins and one when the message is closed. The unit keeps a running CRC-8 over the whole transaction. A repeated start does not restart that CRC, so on a read the checksum covers the write address, the command byte, the read address and the data. For a read, the engine takes the current checksum from `pec_byte` after the target's last data byte and shifts it out as the appended check byte.

On a write, the engine supplies the command's expected byte count and a flag that says whether the command demands a check byte. At the close of the message the unit compares the number of bytes received with that count. An exact count means no check byte was sent. One extra byte means the last byte is a check byte, and the unit tests it. Any other count is a framing mismatch. The verdict is registered and held until the next close. A mismatching check byte also produces a one-cycle `pec_err` event for the alert and status logic.

Top module: `smbus_pec_unit`

## Requirements
- R1: While reset is active, and after it, until the first message, `pec_byte` is 0x00 and `done`, `has_pec`, `pec_ok`, `exec_en` and `pec_err` are all 0.
- R2: The checksum is a CRC-8 with generator 0x07 (x^8+x^2+x+1), seeded with 0x00 at `msg_start`. Each byte is shifted in MSB first, one byte per `byte_valid` cycle. `pec_byte` shows the CRC of all message bytes so far in the cycle after each byte. With no strobe, `pec_byte` holds its value.
- R3: Only `msg_start` reseeds the CRC. For a read transaction (write address, command, read address, data, with no `msg_start` at the repeated start), `pec_byte` after the last data byte equals the CRC over all of those bytes.
- R4: At `msg_end`, a byte count equal to `exp_len` gives `has_pec`=0, `pec_ok`=0 and `pec_err`=0. It gives `exec_en`=1 only when `pec_req`=0.
- R5: At `msg_end`, a byte count of `exp_len`+1 gives `has_pec`=1. `pec_ok`=1 exactly when the last byte equals the CRC of the bytes before it, which is when the CRC over all bytes is 0x00. Then `exec_en`=`pec_ok` and `pec_err`=!`pec_ok`.
- R6: At `msg_end`, any other byte count gives `has_pec`, `pec_ok`, `exec_en` and `pec_err` all 0.
- R7: `done` is high for exactly the one cycle after each `msg_end`. `pec_err` is high only in that cycle. `has_pec`, `pec_ok` and `exec_en` change only then and hold until the next `msg_end`.
- R8: A byte strobed in the same cycle as `msg_start` is the first byte of the new message.
- R9: A byte strobed in the same cycle as `msg_end` is counted and checked as the last byte of the message being closed.
- R10: When `msg_start` and `msg_end` coincide, the close judges the old message and excludes any byte in that cycle. That byte opens the new message.
- R11: The byte count saturates at 2^`CNT_W`-1 and never wraps. With `exp_len`=0, a 65-byte message gives `has_pec`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msg_start | input | 1 | First-cycle strobe of a new message; reseeds CRC and count |
| byte_valid | input | 1 | A bus byte is present on `byte_data` |
| byte_data | input | 8 | Byte transferred on the bus, either direction |
| msg_end | input | 1 | Close strobe; judges the message |
| exp_len | input | CNT_W | Expected write length in bytes, check byte excluded |
| pec_req | input | 1 | Command must carry a valid check byte to execute |
| pec_byte | output | 8 | Running CRC; the check byte to append on reads |
| done | output | 1 | One-cycle pulse after each close |
| has_pec | output | 1 | Closed message carried a check byte |
| pec_ok | output | 1 | Carried check byte matched |
| exec_en | output | 1 | Closed write may be executed |
| pec_err | output | 1 | One-cycle check-byte mismatch event |

## Verification
The risky overlaps are a data byte landing in the same cycle as the open or close strobe, and the open and close strobes landing together. The bench drives a check byte in the same cycle as `msg_end` and requires a passing verdict. It then closes a complete message with a cycle that also opens the next one and carries its first byte. The old message must be judged without that byte, and `pec_byte` must then equal the CRC of the new byte alone. A stale leftover CRC before an open-with-byte shows that reseeding and the first update fold into one cycle.

// File: rtl/smbus_pec_pkg.sv
package smbus_pec_pkg;

  localparam int unsigned CRC_W    = 8;
  localparam logic [7:0]  CRC_POLY = 8'h07;
  localparam logic [7:0]  CRC_SEED = 8'h00;

  typedef struct packed {
    logic has_pec;
    logic pec_ok;
    logic exec_en;
    logic pec_err;
  } verdict_t;

endpackage

// File: rtl/pec_crc_step.sv
module pec_crc_step #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic [W-1:0] crc_in,
  input  logic [7:0]   data_in,
  output logic [W-1:0] crc_out
);

  // one byte, most significant bit first, fully unrolled
  always_comb begin
    logic [W-1:0] acc;
    logic         fb;
    acc = crc_in;
    for (int b = 7; b >= 0; b--) begin
      fb  = acc[W-1] ^ data_in[b];
      acc = {acc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_out = acc;
  end

endmodule

// File: rtl/pec_crc_reg.sv
module pec_crc_reg #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] POLY = 8'h07,
  parameter logic [W-1:0] SEED = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msg_start,
  input  logic         byte_valid,
  input  logic [7:0]   byte_data,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_close
);

  logic [W-1:0] run_next;
  logic [W-1:0] seed_next;
  logic [W-1:0] crc_d;
  logic         crc_en;

  pec_crc_step #(.W(W), .POLY(POLY)) u_run (
    .crc_in  (crc_q),
    .data_in (byte_data),
    .crc_out (run_next)
  );

  pec_crc_step #(.W(W), .POLY(POLY)) u_seed (
    .crc_in  (SEED),
    .data_in (byte_data),
    .crc_out (seed_next)
  );

  // value seen by a close in this cycle: a start in the same cycle
  // keeps its byte out of the message being closed
  always_comb begin
    if (!msg_start && byte_valid) crc_close = run_next;
    else                          crc_close = crc_q;
  end

  always_comb begin
    crc_en = msg_start | byte_valid;
    if (msg_start) crc_d = byte_valid ? seed_next : SEED;
    else           crc_d = run_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SEED;
    else if (crc_en) crc_q <= crc_d;
  end

endmodule

// File: rtl/pec_len_counter.sv
module pec_len_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic             byte_valid,
  output logic [CNT_W-1:0] cnt_close
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    if (!msg_start && byte_valid) cnt_close = cnt_inc;
    else                          cnt_close = cnt_q;
    cnt_en = msg_start | byte_valid;
    if (msg_start) cnt_d = byte_valid ? {{(CNT_W-1){1'b0}}, 1'b1} : '0;
    else           cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pec_verdict.sv
module pec_verdict
  import smbus_pec_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_end,
  input  logic [CNT_W-1:0] cnt_close,
  input  logic [CNT_W-1:0] exp_len,
  input  logic             pec_req,
  input  logic [W-1:0]     crc_close,
  output logic             done,
  output verdict_t         verdict
);

  logic [CNT_W:0] cnt_wide;
  logic [CNT_W:0] exp_wide;
  logic           len_plain;
  logic           len_pec;
  logic           crc_zero;
  verdict_t       vd_d;
  verdict_t       vd_q;
  logic           done_q;

  always_comb begin
    cnt_wide  = {1'b0, cnt_close};
    exp_wide  = {1'b0, exp_len};
    len_plain = (cnt_wide == exp_wide);
    len_pec   = (cnt_wide == exp_wide + 1'b1);
    crc_zero  = (crc_close == '0);
    vd_d      = '0;
    if (len_plain) begin
      vd_d.exec_en = ~pec_req;
    end else if (len_pec) begin
      vd_d.has_pec = 1'b1;
      vd_d.pec_ok  = crc_zero;
      vd_d.exec_en = crc_zero;
      vd_d.pec_err = ~crc_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= msg_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_q <= '0;
    end else if (msg_end) begin
      vd_q <= vd_d;
    end else begin
      vd_q.pec_err <= 1'b0;
    end
  end

  assign done    = done_q;
  assign verdict = vd_q;

endmodule

// File: rtl/smbus_pec_unit.sv
module smbus_pec_unit
  import smbus_pec_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             msg_end,
  input  logic [CNT_W-1:0] exp_len,
  input  logic             pec_req,
  output logic [7:0]       pec_byte,
  output logic             done,
  output logic             has_pec,
  output logic             pec_ok,
  output logic             exec_en,
  output logic             pec_err
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  logic [CRC_W-1:0]       crc_q;
  logic [CRC_W-1:0]       crc_close;
  logic [CNT_W-1:0]       cnt_close;
  verdict_t               verdict;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  pec_crc_reg #(.W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .msg_start  (msg_start),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .crc_q      (crc_q),
    .crc_close  (crc_close)
  );

  pec_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .msg_start  (msg_start),
    .byte_valid (byte_valid),
    .cnt_close  (cnt_close)
  );

  pec_verdict #(.CNT_W(CNT_W), .W(CRC_W)) u_vd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .msg_end   (msg_end),
    .cnt_close (cnt_close),
    .exp_len   (exp_len),
    .pec_req   (pec_req),
    .crc_close (crc_close),
    .done      (done),
    .verdict   (verdict)
  );

  assign pec_byte = crc_q;
  assign has_pec  = verdict.has_pec;
  assign pec_ok   = verdict.pec_ok;
  assign exec_en  = verdict.exec_en;
  assign pec_err  = verdict.pec_err;

endmodule

// File: rtl/smbus_pec_unit_chk.sv
module smbus_pec_unit_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_start,
  input logic             byte_valid,
  input logic [7:0]       byte_data,
  input logic             msg_end,
  input logic [CNT_W-1:0] exp_len,
  input logic             pec_req,
  input logic [7:0]       pec_byte,
  input logic             done,
  input logic             has_pec,
  input logic             pec_ok,
  input logic             exec_en,
  input logic             pec_err
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (pec_byte == 8'h00 && !done && !has_pec && !pec_ok && !exec_en && !pec_err));

  // R2
  start_reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_start && !byte_valid) |=> (pec_byte == 8'h00));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_start && !byte_valid) |=> $stable(pec_byte));

  // R4
  req_blocks_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end && !msg_start && !byte_valid && pec_req) |=> (!exec_en || has_pec));

  // R5
  ok_needs_pec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pec_ok |-> has_pec);

  // R5
  exec_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && has_pec) |-> pec_ok);

  // R7
  err_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pec_err |-> done);

  // R7
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(has_pec) && $stable(pec_ok) && $stable(exec_en)));

endmodule

bind smbus_pec_unit smbus_pec_unit_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/smbus_pec_unit_test.sv
`timescale 1ns/1ps
module smbus_pec_unit_test;

  localparam int unsigned CNT_W = 6;

  logic             clk;
  logic             rst_n;
  logic             msg_start;
  logic             byte_valid;
  logic [7:0]       byte_data;
  logic             msg_end;
  logic [CNT_W-1:0] exp_len;
  logic             pec_req;
  logic [7:0]       pec_byte;
  logic             done;
  logic             has_pec;
  logic             pec_ok;
  logic             exec_en;
  logic             pec_err;

  int n_chk;
  int n_bad;
  logic [7:0] crc;

  smbus_pec_unit #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .msg_end(msg_end), .exp_len(exp_len), .pec_req(pec_req),
    .pec_byte(pec_byte), .done(done), .has_pec(has_pec), .pec_ok(pec_ok),
    .exec_en(exec_en), .pec_err(pec_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [2:0]  nb;
    logic [47:0] data;
    logic [1:0]  mode;   // 0 none, 1 good check byte, 2 bad check byte
    logic [5:0]  elen;
    logic        req;
    logic        x_exec;
    logic        x_has;
    logic        x_ok;
    logic        x_err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{3'd3, 48'hB00180_000000, 2'd0, 6'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{3'd3, 48'hB00180_000000, 2'd1, 6'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{3'd3, 48'hB00180_000000, 2'd2, 6'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{3'd3, 48'hB00180_000000, 2'd0, 6'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd3, 48'hB00180_000000, 2'd1, 6'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{3'd2, 48'hB001_00000000, 2'd0, 6'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd5, 48'hB00180_5566_00, 2'd0, 6'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd4, 48'hB0213412_0000, 2'd2, 6'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{3'd1, 48'hB0_0000000000, 2'd1, 6'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  function automatic logic [7:0] crc_of(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, return at the next falling edge
  task automatic cyc(input logic s, input logic v, input logic [7:0] b, input logic e);
    msg_start  = s;
    byte_valid = v;
    byte_data  = b;
    msg_end    = e;
    @(negedge clk);
    msg_start  = 1'b0;
    byte_valid = 1'b0;
    byte_data  = 8'h00;
    msg_end    = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [7:0] p;
    logic       hold_exec;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    msg_start = 1'b0; byte_valid = 1'b0; byte_data = 8'h00; msg_end = 1'b0;
    exp_len = '0; pec_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 pec_byte in reset", pec_byte, 8'h00);
    chk("R1 flags in reset", {3'b0, done, has_pec, pec_ok, exec_en, pec_err}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 flags after reset", {3'b0, done, has_pec, pec_ok, exec_en, pec_err}, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      crc = 8'h00;
      exp_len = VEC[i].elen;
      pec_req = VEC[i].req;
      for (int k = 0; k < int'(VEC[i].nb); k++) begin
        b = VEC[i].data[47-8*k -: 8];
        cyc(k == 0, 1'b1, b, 1'b0);
        crc = crc_of(crc, b);
        chk("R2 running crc", pec_byte, crc);
      end
      if (VEC[i].mode != 2'd0) begin
        p = (VEC[i].mode == 2'd1) ? crc : (crc ^ 8'h5A);
        cyc(1'b0, 1'b1, p, 1'b0);
        crc = crc_of(crc, p);
        chk("R2 crc after check byte", pec_byte, crc);
      end
      cyc(1'b0, 1'b0, 8'h00, 1'b1);
      chk("R7 done after close", {7'b0, done}, 8'h01);
      chk("R4 R5 R6 has_pec", {7'b0, has_pec}, {7'b0, VEC[i].x_has});
      chk("R5 pec_ok", {7'b0, pec_ok}, {7'b0, VEC[i].x_ok});
      chk("R4 R5 R6 exec_en", {7'b0, exec_en}, {7'b0, VEC[i].x_exec});
      chk("R5 pec_err", {7'b0, pec_err}, {7'b0, VEC[i].x_err});
      cyc(1'b0, 1'b0, 8'h00, 1'b0);
      chk("R7 done single cycle", {7'b0, done, pec_err}, 8'h00);
      chk("R7 exec_en held", {7'b0, exec_en}, {7'b0, VEC[i].x_exec});
      chk("R2 idle holds crc", pec_byte, crc);
    end

    // R3: read transaction spanning a repeated start
    crc = 8'h00;
    cyc(1'b1, 1'b1, 8'hB0, 1'b0); crc = crc_of(crc, 8'hB0);
    cyc(1'b0, 1'b1, 8'h8B, 1'b0); crc = crc_of(crc, 8'h8B);
    cyc(1'b0, 1'b0, 8'h00, 1'b0);
    cyc(1'b0, 1'b1, 8'hB1, 1'b0); crc = crc_of(crc, 8'hB1);
    cyc(1'b0, 1'b1, 8'h34, 1'b0); crc = crc_of(crc, 8'h34);
    cyc(1'b0, 1'b1, 8'h12, 1'b0); crc = crc_of(crc, 8'h12);
    chk("R3 read check byte", pec_byte, crc);

    // R8: start with first byte over a stale crc
    cyc(1'b1, 1'b1, 8'hC4, 1'b0);
    chk("R8 first byte with start", pec_byte, crc_of(8'h00, 8'hC4));

    // R9: check byte together with close
    exp_len = 6'd3; pec_req = 1'b1;
    crc = 8'h00;
    cyc(1'b1, 1'b1, 8'hB0, 1'b0); crc = crc_of(crc, 8'hB0);
    cyc(1'b0, 1'b1, 8'h01, 1'b0); crc = crc_of(crc, 8'h01);
    cyc(1'b0, 1'b1, 8'h80, 1'b0); crc = crc_of(crc, 8'h80);
    cyc(1'b0, 1'b1, crc, 1'b1);
    chk("R9 byte at close counted", {6'b0, has_pec, pec_ok}, 8'h03);
    chk("R9 exec with close byte", {7'b0, exec_en}, 8'h01);

    // R10: close and open together, byte goes to new message
    exp_len = 6'd3; pec_req = 1'b0;
    crc = 8'h00;
    cyc(1'b1, 1'b1, 8'hB0, 1'b0); crc = crc_of(crc, 8'hB0);
    cyc(1'b0, 1'b1, 8'h02, 1'b0); crc = crc_of(crc, 8'h02);
    cyc(1'b0, 1'b1, 8'h40, 1'b0); crc = crc_of(crc, 8'h40);
    cyc(1'b1, 1'b1, 8'h77, 1'b1);
    chk("R10 old message judged alone", {6'b0, has_pec, exec_en}, 8'h01);
    chk("R10 new message crc", pec_byte, crc_of(8'h00, 8'h77));
    cyc(1'b0, 1'b1, 8'h9C, 1'b0);
    cyc(1'b0, 1'b1, 8'hAB, 1'b1);
    chk("R10 new message count", {6'b0, has_pec, exec_en}, 8'h01);

    // R11: 65 bytes against expected length 0
    exp_len = 6'd0; pec_req = 1'b0;
    for (int k = 0; k < 65; k++) cyc(k == 0, 1'b1, 8'(k), 1'b0);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R11 saturated count no pec", {6'b0, has_pec, exec_en}, 8'h00);

    // R7: verdict held across idle cycles
    hold_exec = exec_en;
    repeat (3) cyc(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R7 verdict held idle", {7'b0, exec_en}, {7'b0, hold_exec});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule